// File: doc/BRIEF.md
# Strobe-Addressed Sequential ROM Reader with Dual GPIO Ports

This block sits between a host bus and a 256K-byte read-only store. The host uses active-low chip-select, write and read strobes, a 3-bit register select and a byte-wide data bus. It loads an 18-bit read pointer one byte lane at a time. It then pulls ROM bytes one after another: each rising edge of the read strobe moves the pointer to the next location. The same register select also reaches two 8-bit general-purpose ports, each with an output register and a per-pin direction register.

The strobes are asynchronous to the system clock. They pass through synchronizers, and edges are detected in the clock domain. The ROM contents come from a lookup function computed in logic, so no memory image is needed. The data bus is split into a read value `bus_rd` and its drive enable `bus_drv`. A pad ring combines them with `bus_wr` into the bidirectional pins. Each port is brought out the same way, with a pin output, a pin enable and a pin input.

The host interface has no handshake. A transfer is complete when its strobe rises, and the host keeps the select and the write data stable until the result has taken effect.

Top module: `seqrom_host`

## Requirements
- R1: After reset the read pointer is 0, both port output registers are 0, both direction registers are 0 (every port pin is an input, enable low), and the bus is not driven (`bus_drv` = 0).
- R2: A rising edge of `wr_n` while the chip is selected stores `bus_wr` in the register named by `reg_sel`. Code 1 stores pointer bits 7:0, code 2 stores bits 15:8, code 3 stores bits 17:16 from `bus_wr[1:0]`, code 4 stores the port A output register, code 5 the port A direction, code 6 the port B output register and code 7 the port B direction.
- R3: A read with `reg_sel` 1, 2 or 3 returns pointer bits 7:0, 15:8 or {6'b0, bits 17:16}. A read with code 5 or 7 returns the port A or port B direction register.
- R4: A read with `reg_sel` = 0 returns ROM byte (a[7:0] + 3*a[15:8] + 85*a[17:16]) mod 256, where a is the current pointer.
- R5: A rising edge of `rd_n` with `reg_sel` = 0 while selected adds one to the pointer. A read with any other code leaves it unchanged.
- R6: Incrementing the pointer from 0x3FFFF gives 0x00000.
- R7: Each port pin enable equals its direction bit (1 = output), and each pin output equals the port output register bit.
- R8: A read with code 4 or 6 returns, per bit, the output register bit where the direction is 1 and the pin level sampled one clock earlier where the direction is 0.
- R9: While `cs_n` is high, writes do not change any register, reads do not drive the bus, and `rd_n` edges do not move the pointer.
- R10: While `rd_n` is high, or while `wr_n` is low, `bus_drv` is 0 and `bus_rd` is 0x00.
- R11: A write with `reg_sel` = 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, the write takes effect on its rising edge |
| rd_n | input | 1 | Read strobe, active low, the pointer steps on its rising edge |
| reg_sel | input | 3 | Register select code |
| bus_wr | input | 8 | Write data from the host |
| bus_rd | output | 8 | Read data to the host, 0 when not driven |
| bus_drv | output | 1 | Drive enable for the host data bus |
| pa_pin_in | input | 8 | Port A pin levels |
| pa_pin_out | output | 8 | Port A pin output values |
| pa_pin_oe | output | 8 | Port A pin output enables |
| pb_pin_in | input | 8 | Port B pin levels |
| pb_pin_out | output | 8 | Port B pin output values |
| pb_pin_oe | output | 8 | Port B pin output enables |

## Verification
A strobe level passes through two flops. A write, or a pointer step, therefore lands on the third rising clock edge after the strobe rises. `bus_drv` goes high on the second edge after `rd_n` falls, and a new pin level reaches the port read path after one edge. The bench changes inputs on falling edges and holds each strobe low for three cycles. It samples read data on the falling edge three cycles after `rd_n` falls, and it waits four cycles after every rising strobe before the next access or check. Each sample is therefore at least half a cycle past the last edge that could change the value. The port sweep runs every direction byte on both ports, and the pointer checks cover a long ascending run and the wrap at the top address.

// File: rtl/seqrom_pkg.sv
package seqrom_pkg;

  // Register select codes. The pointer lanes must stay at 1..3 in order,
  // and the port codes must stay in data/direction pairs.
  typedef enum logic [2:0] {
    SEL_ROM    = 3'd0,
    SEL_PTR_LO = 3'd1,
    SEL_PTR_MD = 3'd2,
    SEL_PTR_HI = 3'd3,
    SEL_PA_DAT = 3'd4,
    SEL_PA_DIR = 3'd5,
    SEL_PB_DAT = 3'd6,
    SEL_PB_DIR = 3'd7
  } reg_sel_e;

  localparam int LANE_W     = 8;
  localparam int ROM_ARG_W  = 24;
  localparam int PTR_BASE   = 1;
  localparam int PORT_BASE  = 4;

  // Computed ROM contents: a mix of the three address bytes.
  function automatic logic [7:0] rom_byte(input logic [ROM_ARG_W-1:0] a);
    logic [7:0] b0, b1, b2;
    b0 = a[7:0];
    b1 = a[15:8] * 8'd3;
    b2 = a[23:16] * 8'd85;
    return b0 + b1 + b2;
  endfunction

endpackage

// File: rtl/seqrom_edge_sync.sv
module seqrom_edge_sync #(
  parameter int N      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  localparam int DEPTH = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [DEPTH-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '1;
      else        sh <= {sh[DEPTH-2:0], raw[i]};
    end

    assign lvl[i]  = sh[STAGES-1];
    assign rise[i] = sh[STAGES-1] & ~sh[STAGES];
  end

endmodule

// File: rtl/seqrom_ptr.sv
module seqrom_ptr #(
  parameter int ADDR_W = 18,
  parameter int LANES  = (ADDR_W + 7) / 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [LANES-1:0]    lane_we,
  input  logic [7:0]          wdata,
  input  logic                step,
  output logic [ADDR_W-1:0]   addr,
  output logic [LANES*8-1:0]  addr_wide
);

  localparam int WIDE_W = LANES * 8;

  logic [ADDR_W-1:0] ctr;
  logic [WIDE_W-1:0] merged;
  logic [ADDR_W-1:0] nxt;

  always_comb begin
    merged = '0;
    merged[ADDR_W-1:0] = ctr;
    for (int l = 0; l < LANES; l++) begin
      if (lane_we[l]) merged[l*8 +: 8] = wdata;
    end
  end

  always_comb begin
    if (|lane_we)  nxt = merged[ADDR_W-1:0];
    else if (step) nxt = ctr + 1'b1;
    else           nxt = ctr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr <= '0;
    else        ctr <= nxt;
  end

  assign addr      = ctr;
  assign addr_wide = WIDE_W'(ctr);

endmodule

// File: rtl/seqrom_gpio.sv
module seqrom_gpio #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         out_we,
  input  logic         dir_we,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] rd_val
);

  logic [W-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      pin_q <= '0;
    end else begin
      pin_q <= pin_in;
      if (out_we) out_q <= wdata;
      if (dir_we) dir_q <= wdata;
    end
  end

  assign rd_val = (dir_q & out_q) | (~dir_q & pin_q);

endmodule

// File: rtl/seqrom_host.sv
module seqrom_host
  import seqrom_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int SYNC_STAGES = 2,
  parameter int PORT_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [2:0]        reg_sel,
  input  logic [7:0]        bus_wr,
  output logic [7:0]        bus_rd,
  output logic              bus_drv,
  input  logic [PORT_W-1:0] pa_pin_in,
  output logic [PORT_W-1:0] pa_pin_out,
  output logic [PORT_W-1:0] pa_pin_oe,
  input  logic [PORT_W-1:0] pb_pin_in,
  output logic [PORT_W-1:0] pb_pin_out,
  output logic [PORT_W-1:0] pb_pin_oe
);

  localparam int LANES  = (ADDR_W + 7) / 8;
  localparam int NPORTS = 2;

  reg_sel_e sel_t;
  assign sel_t = reg_sel_e'(reg_sel);

  // chip select: level only
  logic [SYNC_STAGES-1:0] cs_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_sh <= '1;
    else        cs_sh <= {cs_sh[SYNC_STAGES-2:0], cs_n};
  end

  logic cs_s;
  assign cs_s = cs_sh[SYNC_STAGES-1];

  // write and read strobes: level and rising edge
  logic [1:0] stb_lvl, stb_rise;
  seqrom_edge_sync #(.N(2), .STAGES(SYNC_STAGES)) u_stb (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  ({rd_n, wr_n}),
    .lvl  (stb_lvl),
    .rise (stb_rise)
  );

  logic wr_s, rd_s, wr_rise, rd_rise, active, wr_go, step;
  assign wr_s    = stb_lvl[0];
  assign rd_s    = stb_lvl[1];
  assign wr_rise = stb_rise[0];
  assign rd_rise = stb_rise[1];
  assign active  = ~cs_s;
  assign wr_go   = wr_rise & active;
  assign step    = rd_rise & active & (sel_t == SEL_ROM);

  // read pointer
  logic [LANES-1:0]   lane_we;
  logic [ADDR_W-1:0]  addr;
  logic [LANES*8-1:0] addr_wide;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_we[l] = wr_go & (reg_sel == 3'(PTR_BASE + l));
  end

  seqrom_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_we  (lane_we),
    .wdata    (bus_wr),
    .step     (step),
    .addr     (addr),
    .addr_wide(addr_wide)
  );

  // expansion ports
  logic [PORT_W-1:0] pin_a [NPORTS];
  logic [PORT_W-1:0] out_a [NPORTS];
  logic [PORT_W-1:0] dir_a [NPORTS];
  logic [PORT_W-1:0] rdv_a [NPORTS];

  assign pin_a[0] = pa_pin_in;
  assign pin_a[1] = pb_pin_in;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic dat_we, dir_we;
    assign dat_we = wr_go & (reg_sel == 3'(PORT_BASE + 2*p));
    assign dir_we = wr_go & (reg_sel == 3'(PORT_BASE + 2*p + 1));

    seqrom_gpio #(.W(PORT_W)) u_gpio (
      .clk   (clk),
      .rst_n (rst_n),
      .out_we(dat_we),
      .dir_we(dir_we),
      .wdata (bus_wr),
      .pin_in(pin_a[p]),
      .out_q (out_a[p]),
      .dir_q (dir_a[p]),
      .rd_val(rdv_a[p])
    );
  end

  assign pa_pin_out = out_a[0];
  assign pa_pin_oe  = dir_a[0];
  assign pb_pin_out = out_a[1];
  assign pb_pin_oe  = dir_a[1];

  // read path
  logic [7:0] rd_mux;
  always_comb begin
    case (sel_t)
      SEL_ROM:    rd_mux = rom_byte(ROM_ARG_W'(addr));
      SEL_PTR_LO: rd_mux = addr_wide[7:0];
      SEL_PTR_MD: rd_mux = addr_wide[15:8];
      SEL_PTR_HI: rd_mux = addr_wide[23:16];
      SEL_PA_DAT: rd_mux = 8'(rdv_a[0]);
      SEL_PA_DIR: rd_mux = 8'(dir_a[0]);
      SEL_PB_DAT: rd_mux = 8'(rdv_a[1]);
      default:    rd_mux = 8'(dir_a[1]);
    endcase
  end

  assign bus_drv = active & ~rd_s & wr_s;
  assign bus_rd  = bus_drv ? rd_mux : 8'h00;

endmodule

// File: rtl/seqrom_host_chk.sv
module seqrom_host_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              rd_s,
  input logic              wr_rise,
  input logic              rd_rise,
  input logic [2:0]        reg_sel,
  input logic [7:0]        bus_wr,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        pa_out,
  input logic [7:0]        pa_dir,
  input logic [7:0]        pb_out,
  input logic [7:0]        pb_dir,
  input logic              bus_drv,
  input logic [7:0]        bus_rd
);

  // R5 R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !cs_s && reg_sel == 3'd0 && !wr_rise)
      |=> addr == ADDR_W'($past(addr) + 1'b1));

  // R9
  standby_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> ($stable(addr) && $stable(pa_out) && $stable(pa_dir)
              && $stable(pb_out) && $stable(pb_dir)));

  // R11
  rom_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && reg_sel == 3'd0 && !rd_rise)
      |=> ($stable(addr) && $stable(pa_out) && $stable(pa_dir)
           && $stable(pb_out) && $stable(pb_dir)));

  // R2
  port_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !cs_s && reg_sel == 3'd4) |=> pa_out == $past(bus_wr));

  // R10
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_s |-> (!bus_drv && bus_rd == 8'h00));

endmodule

bind seqrom_host seqrom_host_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cs_s   (cs_s),
  .rd_s   (rd_s),
  .wr_rise(wr_rise),
  .rd_rise(rd_rise),
  .reg_sel(reg_sel),
  .bus_wr (bus_wr),
  .addr   (addr),
  .pa_out (pa_pin_out),
  .pa_dir (pa_pin_oe),
  .pb_out (pb_pin_out),
  .pb_dir (pb_pin_oe),
  .bus_drv(bus_drv),
  .bus_rd (bus_rd)
);

// File: tb/seqrom_host_test.sv
module seqrom_host_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, cs_n, wr_n, rd_n;
  logic [2:0] reg_sel;
  logic [7:0] bus_wr, bus_rd;
  logic       bus_drv;
  logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;

  seqrom_host uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .reg_sel   (reg_sel),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_drv   (bus_drv),
    .pa_pin_in (pa_in),
    .pa_pin_out(pa_out),
    .pa_pin_oe (pa_oe),
    .pb_pin_in (pb_in),
    .pb_pin_out(pb_out),
    .pb_pin_oe (pb_oe)
  );

  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;
  logic last_drv;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    reg_sel = s;
    bus_wr  = d;
    wr_n    = 1'b0;
    tick(3);
    wr_n = 1'b1;
    tick(4);
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] v);
    reg_sel = s;
    rd_n    = 1'b0;
    tick(3);
    v        = bus_rd;
    last_drv = bus_drv;
    rd_n = 1'b1;
    tick(4);
  endtask

  task automatic set_ptr(input logic [17:0] a);
    wr(3'd1, a[7:0]);
    wr(3'd2, a[15:8]);
    wr(3'd3, {6'b0, a[17:16]});
  endtask

  task automatic get_ptr(output logic [17:0] a);
    logic [7:0] b0, b1, b2;
    rd(3'd1, b0);
    rd(3'd2, b1);
    rd(3'd3, b2);
    a = {b2[1:0], b1, b0};
  endtask

  function automatic logic [7:0] model_rom(input int a);
    int s;
    s = (a % 256) + 3 * ((a / 256) % 256) + 85 * (a / 65536);
    return 8'(s % 256);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [17:0] a;
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    reg_sel = 3'd0; bus_wr = 8'h00; pa_in = 8'h00; pb_in = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(3);

    // R1 reset state
    check("R1 bus_drv", 32'(bus_drv), 0);
    check("R1 pa_oe", 32'(pa_oe), 0);
    check("R1 pb_oe", 32'(pb_oe), 0);
    check("R1 pa_out", 32'(pa_out), 0);
    check("R1 pb_out", 32'(pb_out), 0);
    cs_n = 1'b0;
    tick(3);
    // R10 idle bus
    check("R10 idle drv", 32'(bus_drv), 0);
    check("R10 idle data", 32'(bus_rd), 0);
    get_ptr(a);
    check("R1 pointer", 32'(a), 0);

    // R2 R3 lane loads and read-back
    set_ptr(18'h2A5C3);
    rd(3'd1, v); check("R3 ptr lo", 32'(v), 32'hC3);
    check("R10 drive during read", 32'(last_drv), 1);
    rd(3'd2, v); check("R3 ptr mid", 32'(v), 32'hA5);
    rd(3'd3, v); check("R2 ptr hi", 32'(v), 32'h02);

    // R4 R5 sequential run
    set_ptr(18'h123F0);
    for (int i = 0; i < 48; i++) begin
      rd(3'd0, v);
      check("R4 rom byte", 32'(v), 32'(model_rom(32'h123F0 + i)));
    end
    get_ptr(a);
    check("R5 pointer after run", 32'(a), 32'h123F0 + 48);

    // R6 wrap
    set_ptr(18'h3FFFE);
    rd(3'd0, v); check("R6 byte 3FFFE", 32'(v), 32'(model_rom(32'h3FFFE)));
    rd(3'd0, v); check("R6 byte 3FFFF", 32'(v), 32'(model_rom(32'h3FFFF)));
    rd(3'd0, v); check("R6 byte 0", 32'(v), 32'(model_rom(0)));
    get_ptr(a);
    check("R6 pointer", 32'(a), 1);

    // R5 other codes do not step
    rd(3'd4, v);
    rd(3'd7, v);
    get_ptr(a);
    check("R5 no step", 32'(a), 1);

    // R11 write to ROM code ignored
    wr(3'd0, 8'h77);
    get_ptr(a);
    check("R11 pointer", 32'(a), 1);
    check("R11 pa_out", 32'(pa_out), 0);
    check("R11 pa_oe", 32'(pa_oe), 0);

    // R7 R8 R3 direction sweep on both ports
    for (int p = 0; p < 2; p++) begin
      for (int d = 0; d < 256; d++) begin
        logic [7:0] ov, pv, exp;
        ov = 8'(d) ^ 8'h5A;
        pv = 8'(d * 7 + 13);
        wr(3'(4 + 2 * p), ov);
        wr(3'(5 + 2 * p), 8'(d));
        if (p == 0) pa_in = pv; else pb_in = pv;
        tick(2);
        exp = (8'(d) & ov) | (~8'(d) & pv);
        rd(3'(4 + 2 * p), v);
        check("R8 port read", 32'(v), 32'(exp));
        rd(3'(5 + 2 * p), v);
        check("R3 dir read", 32'(v), 32'(d));
        check("R7 pin oe", 32'(p == 0 ? pa_oe : pb_oe), 32'(d));
        check("R7 pin out", 32'(p == 0 ? pa_out : pb_out), 32'(ov));
      end
    end

    // R9 standby blocks everything
    wr(3'd4, 8'h11);
    wr(3'd5, 8'hF0);
    set_ptr(18'h00100);
    cs_n = 1'b1;
    tick(3);
    wr(3'd4, 8'hEE);
    wr(3'd5, 8'h0F);
    wr(3'd1, 8'h55);
    rd(3'd0, v);
    check("R9 no drive", 32'(last_drv), 0);
    check("R9 no data", 32'(v), 0);
    cs_n = 1'b0;
    tick(3);
    check("R9 pa_out held", 32'(pa_out), 32'h11);
    check("R9 pa_oe held", 32'(pa_oe), 32'hF0);
    get_ptr(a);
    check("R9 pointer held", 32'(a), 32'h100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule